// File: doc/BRIEF.md
# Nonvolatile Write Controller with Power Gating

This block sequences write operations to an on-chip nonvolatile memory. It also decides how those writes interact with system sleep, reset and a low-supply warning. A write starts on a one-cycle start command, provided three conditions hold: no write is already running, the supply monitor is not reporting a near-threshold voltage, and the controller is awake. The memory model answers with a one-cycle done indication. That indication sets a ready flag. The flag drives an interrupt request through an enable bit, and both the flag and the enable are reached through a two-entry register interface.

Sleep requests carry a mode code. When no write is running, the controller follows the system into sleep at once and releases its clock-keep-alive. When a write is running, sleep entry is deferred and the clock stays alive until the write completes, whatever the mode. Two things wake the block: an external wake input in any mode, and the ready interrupt in the idle mode only. Every wake produces a one-cycle page-buffer clear pulse. An asynchronous reset aborts any write in progress.

Top module: `nvm_wr_ctrl`

## Requirements
- R1: When `start_i` is high, no write is busy, `vlow_i` is low and the controller is awake, `mem_start_o` is high in the same cycle and `busy_o` is high from the next cycle until the cycle after `done_i` is sampled high.
- R2: While `vlow_i` is high, or while sleep is deferred or active, a start request produces no `mem_start_o` and leaves `busy_o` low.
- R3: A start request while `busy_o` is high is ignored: `mem_start_o` stays low and `busy_o` stays high until `done_i`.
- R4: `done_i` sampled while busy sets the ready flag, which is bit 0 of register address 0, in the next cycle. `done_i` sampled while not busy does not set it.
- R5: `irq_o` equals the ready flag ANDed with the enable bit, which is bit 0 of register address 1. It stays high until the flag is cleared.
- R6: Writing 1 to bit 0 of address 0 clears the ready flag. Writing 0 leaves it unchanged. If a set and a clear fall in the same cycle, the set wins.
- R7: A sleep request (`sleep_req_i`) with no write running or starting gives `asleep_o` high and `clk_keep_o` low from the next cycle.
- R8: A sleep request during a write keeps `clk_keep_o` high and `asleep_o` low until `done_i`. Both change in the cycle after `done_i` is sampled. This holds for every mode code.
- R9: Mode code 1 is idle, 2 is standby and 3 is power-down; code 0 behaves like standby. While asleep, `irq_o` wakes the block only when the stored mode is idle.
- R10: `ext_wake_i` wakes the block from any sleep mode.
- R11: A wake gives `wake_o` and `pbuf_clr_o` high for exactly one cycle, in the cycle after the wake condition is sampled. `asleep_o` is low in that same cycle.
- R12: Asserting `rst_ni` low during a write clears `busy_o` at once. A later `done_i` then does not set the ready flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Write start command |
| done_i | input | 1 | Write-done indication from the memory model |
| vlow_i | input | 1 | Supply near brown-out level |
| sleep_req_i | input | 1 | System sleep request |
| sleep_mode_i | input | 2 | Sleep mode code |
| ext_wake_i | input | 1 | Wake event from another source |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 flags, 1 enable |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data for `reg_addr_i` |
| mem_start_o | output | 1 | Accepted start to the memory |
| busy_o | output | 1 | Write in progress |
| irq_o | output | 1 | Ready interrupt request (vector 0) |
| clk_keep_o | output | 1 | Keep memory and system clock running |
| asleep_o | output | 1 | Controller in sleep |
| wake_o | output | 1 | Wake pulse |
| pbuf_clr_o | output | 1 | Page-buffer clear pulse |

## Verification
On every cycle, the assertions check four things: start gating by low voltage and busy, busy following an accepted start, the clock being kept alive for as long as a write runs, and the wake pulse lasting one cycle and only after sleep. The interrupt is also checked to persist while no register write occurs. Only the bench scenarios can show the behaviours that depend on mode codes and on sequences: deferred sleep in power-down, waking by the ready interrupt in idle but not in deeper modes, write-one-to-clear semantics, and a reset aborting a write so that a later done is not counted.

// File: rtl/nvm_wr_pkg.sv
package nvm_wr_pkg;
  typedef enum logic [1:0] {
    MODE_RSVD  = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_STBY  = 2'd2,
    MODE_PDOWN = 2'd3
  } slp_mode_e;

  typedef enum logic [1:0] {
    PW_AWAKE = 2'd0,
    PW_DEFER = 2'd1,
    PW_SLEEP = 2'd2
  } pw_state_e;

  localparam logic REG_FLAGS = 1'b0;
  localparam logic REG_INTEN = 1'b1;
  localparam int   RDY_BIT   = 0;
endpackage

// File: rtl/nvm_wr_seq.sv
module nvm_wr_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic done_i,
  input  logic vlow_i,
  input  logic run_ok_i,
  output logic mem_start_o,
  output logic busy_o,
  output logic active_o,
  output logic rdy_set_o
);
  logic busy_q;

  assign mem_start_o = start_i & ~busy_q & ~vlow_i & run_ok_i;
  assign rdy_set_o   = done_i & busy_q;
  assign active_o    = busy_q | mem_start_o;
  assign busy_o      = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          busy_q <= 1'b0;
    else if (mem_start_o) busy_q <= 1'b1;
    else if (rdy_set_o)   busy_q <= 1'b0;
  end
endmodule

// File: rtl/nvm_wr_irq.sv
module nvm_wr_irq
  import nvm_wr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rdy_set_i,
  input  logic          reg_we_i,
  input  logic          reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_o
);
  logic flag_q, en_q;
  logic clr_req;

  assign clr_req = reg_we_i && (reg_addr_i == REG_FLAGS) && reg_wdata_i[RDY_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      flag_q <= rdy_set_i | (flag_q & ~clr_req);  // set wins
      if (reg_we_i && reg_addr_i == REG_INTEN) en_q <= reg_wdata_i[RDY_BIT];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    reg_rdata_o[RDY_BIT] = (reg_addr_i == REG_FLAGS) ? flag_q : en_q;
  end

  assign irq_o = flag_q & en_q;
endmodule

// File: rtl/nvm_wr_pwr.sv
module nvm_wr_pwr
  import nvm_wr_pkg::*;
#(
  parameter int MW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sleep_req_i,
  input  logic [MW-1:0] sleep_mode_i,
  input  logic          ext_wake_i,
  input  logic          active_i,
  input  logic          rdy_set_i,
  input  logic          irq_i,
  output logic          run_ok_o,
  output logic          clk_keep_o,
  output logic          asleep_o,
  output logic          wake_o
);
  pw_state_e state_q, state_d;
  logic [MW-1:0] mode_q;
  logic wake_q, wake_req;

  assign wake_req = ext_wake_i | (irq_i & (mode_q == MW'(MODE_IDLE)));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PW_AWAKE: if (sleep_req_i) state_d = active_i ? PW_DEFER : PW_SLEEP;
      PW_DEFER: if (rdy_set_i)   state_d = PW_SLEEP;
      PW_SLEEP: if (wake_req)    state_d = PW_AWAKE;
      default:                   state_d = PW_AWAKE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PW_AWAKE;
      mode_q  <= '0;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == PW_AWAKE && sleep_req_i) mode_q <= sleep_mode_i;
      wake_q  <= (state_q == PW_SLEEP) && wake_req;
    end
  end

  assign run_ok_o   = (state_q == PW_AWAKE);
  assign clk_keep_o = (state_q != PW_SLEEP);
  assign asleep_o   = (state_q == PW_SLEEP);
  assign wake_o     = wake_q;
endmodule

// File: rtl/nvm_wr_ctrl.sv
module nvm_wr_ctrl #(
  parameter int DW = 8,
  parameter int MW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          done_i,
  input  logic          vlow_i,
  input  logic          sleep_req_i,
  input  logic [MW-1:0] sleep_mode_i,
  input  logic          ext_wake_i,
  input  logic          reg_we_i,
  input  logic          reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          mem_start_o,
  output logic          busy_o,
  output logic          irq_o,
  output logic          clk_keep_o,
  output logic          asleep_o,
  output logic          wake_o,
  output logic          pbuf_clr_o
);
  logic run_ok, active, rdy_set, wake;

  nvm_wr_seq u_seq (
    .clk_i, .rst_ni, .start_i, .done_i, .vlow_i,
    .run_ok_i(run_ok), .mem_start_o, .busy_o,
    .active_o(active), .rdy_set_o(rdy_set)
  );

  nvm_wr_irq #(.DW(DW)) u_irq (
    .clk_i, .rst_ni, .rdy_set_i(rdy_set), .reg_we_i, .reg_addr_i,
    .reg_wdata_i, .reg_rdata_o, .irq_o
  );

  nvm_wr_pwr #(.MW(MW)) u_pwr (
    .clk_i, .rst_ni, .sleep_req_i, .sleep_mode_i, .ext_wake_i,
    .active_i(active), .rdy_set_i(rdy_set), .irq_i(irq_o),
    .run_ok_o(run_ok), .clk_keep_o, .asleep_o, .wake_o(wake)
  );

  assign wake_o     = wake;
  assign pbuf_clr_o = wake;
endmodule

// File: rtl/nvm_wr_ctrl_chk.sv
module nvm_wr_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic vlow_i,
  input logic reg_we_i,
  input logic mem_start_o,
  input logic busy_o,
  input logic irq_o,
  input logic clk_keep_o,
  input logic asleep_o,
  input logic wake_o,
  input logic pbuf_clr_o
);
  a_r1_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_start_o |=> busy_o);
  a_r2_no_start_vlow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vlow_i |-> !mem_start_o);
  a_r3_no_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !mem_start_o);
  a_r5_irq_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !reg_we_i) |=> irq_o);
  a_r8_keep_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (clk_keep_o && !asleep_o));
  a_r11_wake_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);
  a_r11_wake_from_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> ($past(asleep_o) && !asleep_o && pbuf_clr_o));
endmodule

bind nvm_wr_ctrl nvm_wr_ctrl_chk u_chk (
  .clk_i, .rst_ni, .vlow_i, .reg_we_i, .mem_start_o, .busy_o, .irq_o,
  .clk_keep_o, .asleep_o, .wake_o, .pbuf_clr_o
);

// File: tb/nvm_wr_ctrl_bench.sv
`timescale 1ns/1ps
module nvm_wr_ctrl_bench;
  localparam int DW = 8;
  logic clk = 0, rst_ni = 0;
  logic start_i = 0, done_i = 0, vlow_i = 0, sleep_req_i = 0, ext_wake_i = 0;
  logic [1:0] sleep_mode_i = 0;
  logic reg_we_i = 0, reg_addr_i = 0;
  logic [DW-1:0] reg_wdata_i = 0, reg_rdata_o;
  logic mem_start_o, busy_o, irq_o, clk_keep_o, asleep_o, wake_o, pbuf_clr_o;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  nvm_wr_ctrl #(.DW(DW), .MW(2)) u_nvm_wr_ctrl (
    .clk_i(clk), .rst_ni, .start_i, .done_i, .vlow_i, .sleep_req_i, .sleep_mode_i,
    .ext_wake_i, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o, .mem_start_o,
    .busy_o, .irq_o, .clk_keep_o, .asleep_o, .wake_o, .pbuf_clr_o
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  function automatic int rd_flag(); return 0; endfunction

  task automatic read_reg(input logic a, output int v);
    reg_addr_i = a; #0.5; v = int'(reg_rdata_o[0]);
  endtask

  task automatic wr_reg(input logic a, input logic [DW-1:0] d);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d; cyc(); reg_we_i = 0; reg_wdata_i = 0;
  endtask

  // start a write and return after it is accepted (busy visible)
  task automatic begin_write();
    start_i = 1; cyc(); start_i = 0;
  endtask

  task automatic finish_write();
    done_i = 1; cyc(); done_i = 0;
  endtask

  task automatic t_reset();
    int v;
    chk("R1 reset busy", busy_o, 0);
    chk("R5 reset irq", irq_o, 0);
    chk("R7 reset asleep", asleep_o, 0);
    chk("R8 reset keep", clk_keep_o, 1);
    read_reg(0, v); chk("R4 reset flag", v, 0);
  endtask

  task automatic t_start_busy();
    int v;
    start_i = 1; #0.5; chk("R1 start pulse", mem_start_o, 1);
    cyc(); start_i = 0; chk("R1 busy set", busy_o, 1);
    start_i = 1; #0.5; chk("R3 restart ignored", mem_start_o, 0);
    cyc(); start_i = 0; chk("R3 still busy", busy_o, 1);
    finish_write();
    chk("R1 busy clear", busy_o, 0);
    read_reg(0, v); chk("R4 flag set", v, 1);
    chk("R5 irq masked", irq_o, 0);
  endtask

  task automatic t_irq_regs();
    int v;
    wr_reg(1, 8'h01);
    chk("R5 irq enabled", irq_o, 1);
    wr_reg(0, 8'h00);
    chk("R6 write0 keeps", irq_o, 1);
    cyc(); chk("R5 irq persists", irq_o, 1);
    wr_reg(0, 8'h01);
    chk("R6 w1c clears", irq_o, 0);
    read_reg(0, v); chk("R6 flag zero", v, 0);
    done_i = 1; cyc(); done_i = 0;
    read_reg(0, v); chk("R4 idle done ignored", v, 0);
    // set wins over clear
    begin_write();
    done_i = 1; reg_we_i = 1; reg_addr_i = 0; reg_wdata_i = 8'h01; cyc();
    done_i = 0; reg_we_i = 0; reg_wdata_i = 0;
    read_reg(0, v); chk("R6 set wins", v, 1);
    wr_reg(0, 8'h01);
  endtask

  task automatic t_vlow();
    vlow_i = 1; start_i = 1; #0.5; chk("R2 vlow refuse", mem_start_o, 0);
    cyc(); start_i = 0; vlow_i = 0; chk("R2 vlow not busy", busy_o, 0);
  endtask

  task automatic t_sleep_ext();
    sleep_mode_i = 2; sleep_req_i = 1; cyc(); sleep_req_i = 0;
    chk("R7 asleep", asleep_o, 1);
    chk("R7 keep off", clk_keep_o, 0);
    start_i = 1; #0.5; chk("R2 no start asleep", mem_start_o, 0);
    cyc(); start_i = 0; chk("R2 not busy asleep", busy_o, 0);
    ext_wake_i = 1; cyc(); ext_wake_i = 0;
    chk("R10 ext wake", asleep_o, 0);
    chk("R11 wake pulse", wake_o, 1);
    chk("R11 pbuf clr", pbuf_clr_o, 1);
    cyc(); chk("R11 wake single", wake_o, 0);
    chk("R11 pbuf single", pbuf_clr_o, 0);
  endtask

  task automatic t_defer_pdown();
    begin_write();
    sleep_mode_i = 3; sleep_req_i = 1; cyc(); sleep_req_i = 0;
    chk("R8 deferred", asleep_o, 0);
    chk("R8 keep on", clk_keep_o, 1);
    cyc(); cyc(); chk("R8 keep held", clk_keep_o, 1);
    finish_write();
    chk("R8 sleep after done", asleep_o, 1);
    chk("R8 keep off after done", clk_keep_o, 0);
    chk("R5 irq in pdown", irq_o, 1);
    cyc(); cyc(); cyc();
    chk("R9 no irq wake pdown", asleep_o, 1);
    chk("R9 no wake pulse", wake_o, 0);
    ext_wake_i = 1; cyc(); ext_wake_i = 0;
    chk("R10 wake pdown", wake_o, 1);
    wr_reg(0, 8'h01);
  endtask

  task automatic t_defer_idle();
    begin_write();
    sleep_mode_i = 1; sleep_req_i = 1; cyc(); sleep_req_i = 0;
    chk("R8 idle deferred", asleep_o, 0);
    finish_write();
    chk("R8 idle asleep", asleep_o, 1);
    cyc();
    chk("R9 irq wakes idle", asleep_o, 0);
    chk("R11 idle wake pulse", wake_o, 1);
    chk("R11 idle pbuf", pbuf_clr_o, 1);
    wr_reg(0, 8'h01);
  endtask

  task automatic t_abort();
    int v;
    begin_write();
    chk("R12 busy before", busy_o, 1);
    rst_ni = 0; #0.5; chk("R12 abort busy", busy_o, 0);
    cyc(); rst_ni = 1;
    finish_write();
    read_reg(0, v); chk("R12 no flag", v, 0);
    chk("R12 no irq", irq_o, 0);
  endtask

  initial begin
    repeat (2) cyc();
    rst_ni = 1; cyc();
    t_reset();
    t_start_busy();
    t_irq_regs();
    t_vlow();
    t_sleep_ext();
    t_defer_pdown();
    t_defer_idle();
    t_abort();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule